// File: doc/BRIEF.md
# Receive Interrupt Coalescing Unit

This block sits beside a receive frame queue and decides when the host should be interrupted. Rather than interrupting on every frame, it tracks how many frames and how many bytes are waiting and how long the oldest waiting frame has been there. It raises a single receive interrupt once any enabled measure goes above its programmable limit.

The queue reports each stored frame with its byte length and each removed frame with its byte length. A free-running tick input gives the time base. Three limits and three enable bits select the active conditions. The host clears the interrupt with an acknowledge strobe. The same strobe captures which conditions held at that moment into three cause-status outputs, so software can see why it was interrupted.

Top module: `rx_coalesce_irq`

## Requirements
- R1: After reset the interrupt output and all three cause-status outputs are 0, and the frame count, byte count and dwell time are 0.
- R2: When the frame-limit enable is 1 and the number of stored frames is strictly greater than the frame limit, the interrupt output is 1 one clock edge after the count update is registered.
- R3: When the byte-limit enable is 1 and the number of stored bytes is strictly greater than the byte limit, the interrupt output is 1 one clock edge after the count update is registered.
- R4: When the dwell enable is 1 and the queue is not empty, the dwell time counts one per clock edge at which tick is 1, starting from 0 at the enqueue into an empty queue. Once the dwell time is strictly greater than the dwell limit, the interrupt output is 1 one edge later.
- R5: The dwell time returns to 0 and stops counting while the queue is empty. It starts again from 0 at the next enqueue.
- R6: An enqueue adds one frame and its length, and a dequeue removes one frame and its length. When both occur in the same cycle, both apply. A dequeue while the queue is empty is ignored.
- R7: Once set, the interrupt output stays 1 until an acknowledge. An acknowledge clears it at the next edge only if no enabled condition holds in the acknowledge cycle; otherwise it stays 1.
- R8: At each acknowledge the status outputs take the conditions that hold in that cycle, with bit meanings dwell (stat_dur), bytes (stat_byte) and frames (stat_frame). Between acknowledges the status outputs hold their value.
- R9: A condition whose enable is 0 neither sets the interrupt nor sets its status bit, whatever its measure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | A frame was stored in the queue this cycle |
| enq_len | input | LEN_W | Byte length of the stored frame |
| deq_valid | input | 1 | A frame was removed from the queue this cycle |
| deq_len | input | LEN_W | Byte length of the removed frame |
| tick | input | 1 | Time base pulse for the dwell timer |
| dur_limit | input | TIME_W | Dwell limit in ticks |
| byte_limit | input | BYTE_W | Stored-byte limit |
| frame_limit | input | FRAME_W | Stored-frame limit |
| dur_en | input | 1 | Enable for the dwell condition |
| byte_en | input | 1 | Enable for the byte condition |
| frame_en | input | 1 | Enable for the frame condition |
| irq_ack | input | 1 | Host acknowledge of the receive interrupt |
| irq | output | 1 | Receive interrupt |
| stat_dur | output | 1 | Dwell condition held at the last acknowledge |
| stat_byte | output | 1 | Byte condition held at the last acknowledge |
| stat_frame | output | 1 | Frame condition held at the last acknowledge |

## Verification
The assertions check on every cycle that the interrupt never drops without an acknowledge, that it rises only after an enabled condition, and that the status bits move only at an acknowledge, where they equal the conditions that held, with disabled causes always 0. They also check that the dwell time is zero whenever the queue is empty and that a simultaneous store and removal leaves the frame count unchanged. The exact arithmetic of the byte count, the strict "greater than" comparisons, the ignored removal from an empty queue and the dwell timer restarting from zero can only be shown by the bench's scenarios with known lengths and tick counts.

// File: rtl/rxc_pkg.sv
package rxc_pkg;

    // Order of fields fixes the status bit order: {dwell, bytes, frames}
    typedef struct packed {
        logic dur;
        logic bytes;
        logic frames;
    } rxc_cause_t;

    localparam int unsigned RXC_NUM_CAUSES = 3;

endpackage

// File: rtl/rxc_occupancy.sv
module rxc_occupancy #(
    parameter int unsigned LEN_W   = 11,
    parameter int unsigned BYTE_W  = 16,
    parameter int unsigned FRAME_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enq_valid,
    input  logic [LEN_W-1:0]   enq_len,
    input  logic               deq_valid,
    input  logic [LEN_W-1:0]   deq_len,
    output logic [FRAME_W-1:0] frames_q_o,
    output logic [BYTE_W-1:0]  bytes_q_o,
    output logic               occupied_d_o
);

    localparam int unsigned SUM_W = BYTE_W + 1;
    localparam logic [FRAME_W-1:0] FRAME_MAX = {FRAME_W{1'b1}};
    localparam logic [BYTE_W-1:0]  BYTE_MAX  = {BYTE_W{1'b1}};

    typedef struct packed {
        logic [FRAME_W-1:0] frames;
        logic [BYTE_W-1:0]  bytes;
    } occ_t;

    occ_t occ_d, occ_q;

    logic             enq_ok;
    logic             deq_ok;
    logic [SUM_W-1:0] add_len;
    logic [SUM_W-1:0] sub_len;
    logic [SUM_W-1:0] grown;
    logic [BYTE_W-1:0] clipped;

    always_comb begin
        occ_d   = occ_q;
        enq_ok  = enq_valid && (occ_q.frames != FRAME_MAX);
        deq_ok  = deq_valid && (occ_q.frames != '0);
        add_len = enq_ok ? SUM_W'(enq_len) : '0;
        sub_len = deq_ok ? SUM_W'(deq_len) : '0;

        grown   = {1'b0, occ_q.bytes} + add_len;
        clipped = grown[SUM_W-1] ? BYTE_MAX : grown[BYTE_W-1:0];

        case ({enq_ok, deq_ok})
            2'b10:   occ_d.frames = occ_q.frames + 1'b1;
            2'b01:   occ_d.frames = occ_q.frames - 1'b1;
            default: occ_d.frames = occ_q.frames;
        endcase

        if ({1'b0, clipped} < sub_len) begin
            occ_d.bytes = '0;
        end else begin
            occ_d.bytes = clipped - sub_len[BYTE_W-1:0];
        end

        if (occ_d.frames == '0) begin
            occ_d.bytes = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q <= '0;
        end else begin
            occ_q <= occ_d;
        end
    end

    assign frames_q_o   = occ_q.frames;
    assign bytes_q_o    = occ_q.bytes;
    assign occupied_d_o = (occ_d.frames != '0);

endmodule

// File: rtl/rxc_dwell_timer.sv
module rxc_dwell_timer #(
    parameter int unsigned TIME_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              occupied_q,
    input  logic              occupied_d,
    output logic [TIME_W-1:0] elapsed_o
);

    localparam logic [TIME_W-1:0] TIME_MAX = {TIME_W{1'b1}};

    typedef struct packed {
        logic [TIME_W-1:0] elapsed;
    } dwell_t;

    dwell_t dw_d, dw_q;

    always_comb begin
        dw_d = dw_q;
        if (!occupied_d || !occupied_q) begin
            // empty now or freshly started: count from zero
            dw_d.elapsed = '0;
        end else if (tick && (dw_q.elapsed != TIME_MAX)) begin
            dw_d.elapsed = dw_q.elapsed + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dw_q <= '0;
        end else begin
            dw_q <= dw_d;
        end
    end

    assign elapsed_o = dw_q.elapsed;

endmodule

// File: rtl/rxc_cause_eval.sv
module rxc_cause_eval
    import rxc_pkg::*;
#(
    parameter int unsigned BYTE_W  = 16,
    parameter int unsigned FRAME_W = 8,
    parameter int unsigned TIME_W  = 16
) (
    input  logic [FRAME_W-1:0] frames,
    input  logic [BYTE_W-1:0]  bytes,
    input  logic [TIME_W-1:0]  elapsed,
    input  logic [TIME_W-1:0]  dur_limit,
    input  logic [BYTE_W-1:0]  byte_limit,
    input  logic [FRAME_W-1:0] frame_limit,
    input  logic               dur_en,
    input  logic               byte_en,
    input  logic               frame_en,
    output rxc_cause_t         cause_o
);

    logic occupied;

    always_comb begin
        occupied       = (frames != '0);
        cause_o.dur    = dur_en   && occupied && (elapsed > dur_limit);
        cause_o.bytes  = byte_en  && (bytes  > byte_limit);
        cause_o.frames = frame_en && (frames > frame_limit);
    end

endmodule

// File: rtl/rx_coalesce_irq.sv
module rx_coalesce_irq
    import rxc_pkg::*;
#(
    parameter int unsigned LEN_W   = 11,
    parameter int unsigned BYTE_W  = 16,
    parameter int unsigned FRAME_W = 8,
    parameter int unsigned TIME_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enq_valid,
    input  logic [LEN_W-1:0]   enq_len,
    input  logic               deq_valid,
    input  logic [LEN_W-1:0]   deq_len,
    input  logic               tick,
    input  logic [TIME_W-1:0]  dur_limit,
    input  logic [BYTE_W-1:0]  byte_limit,
    input  logic [FRAME_W-1:0] frame_limit,
    input  logic               dur_en,
    input  logic               byte_en,
    input  logic               frame_en,
    input  logic               irq_ack,
    output logic               irq,
    output logic               stat_dur,
    output logic               stat_byte,
    output logic               stat_frame
);

    typedef struct packed {
        logic       irq;
        rxc_cause_t stat;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [FRAME_W-1:0] frame_cnt_w;
    logic [BYTE_W-1:0]  byte_cnt_w;
    logic [TIME_W-1:0]  elapsed_w;
    logic               occupied_next_w;
    rxc_cause_t         cause_w;

    rxc_occupancy #(
        .LEN_W  (LEN_W),
        .BYTE_W (BYTE_W),
        .FRAME_W(FRAME_W)
    ) u_occ (
        .clk         (clk),
        .rst_n       (rst_n),
        .enq_valid   (enq_valid),
        .enq_len     (enq_len),
        .deq_valid   (deq_valid),
        .deq_len     (deq_len),
        .frames_q_o  (frame_cnt_w),
        .bytes_q_o   (byte_cnt_w),
        .occupied_d_o(occupied_next_w)
    );

    rxc_dwell_timer #(
        .TIME_W(TIME_W)
    ) u_dwell (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .occupied_q(frame_cnt_w != '0),
        .occupied_d(occupied_next_w),
        .elapsed_o (elapsed_w)
    );

    rxc_cause_eval #(
        .BYTE_W (BYTE_W),
        .FRAME_W(FRAME_W),
        .TIME_W (TIME_W)
    ) u_eval (
        .frames     (frame_cnt_w),
        .bytes      (byte_cnt_w),
        .elapsed    (elapsed_w),
        .dur_limit  (dur_limit),
        .byte_limit (byte_limit),
        .frame_limit(frame_limit),
        .dur_en     (dur_en),
        .byte_en    (byte_en),
        .frame_en   (frame_en),
        .cause_o    (cause_w)
    );

    always_comb begin
        ctl_d     = ctl_q;
        // held until acknowledged; any live cause keeps or sets it
        ctl_d.irq = (ctl_q.irq && !irq_ack) || (|cause_w);
        if (irq_ack) begin
            ctl_d.stat = cause_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign irq        = ctl_q.irq;
    assign stat_dur   = ctl_q.stat.dur;
    assign stat_byte  = ctl_q.stat.bytes;
    assign stat_frame = ctl_q.stat.frames;

endmodule

// File: rtl/rxc_coalesce_chk.sv
module rxc_coalesce_chk #(
    parameter int unsigned FRAME_W = 8,
    parameter int unsigned TIME_W  = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               irq_ack,
    input logic               irq,
    input logic [2:0]         stat,
    input logic [2:0]         cause,
    input logic [2:0]         en,
    input logic               enq_valid,
    input logic               deq_valid,
    input logic [FRAME_W-1:0] frames,
    input logic [TIME_W-1:0]  elapsed
);

    // R7
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !irq_ack |=> irq);

    // R2
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |=> (irq == $past(|cause)));

    // R8
    stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_ack |=> $stable(stat));

    // R8
    stat_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> (stat == $past(cause)));

    // R9
    stat_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> ((stat & ~$past(en)) == 3'b000));

    // R5
    timer_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frames == '0) |-> (elapsed == '0));

    // R6
    frame_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enq_valid && deq_valid && (frames != '0) && (frames != {FRAME_W{1'b1}})
        |=> $stable(frames));

endmodule

bind rx_coalesce_irq rxc_coalesce_chk #(
    .FRAME_W(FRAME_W),
    .TIME_W (TIME_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_ack  (irq_ack),
    .irq      (irq),
    .stat     ({stat_dur, stat_byte, stat_frame}),
    .cause    (cause_w),
    .en       ({dur_en, byte_en, frame_en}),
    .enq_valid(enq_valid),
    .deq_valid(deq_valid),
    .frames   (frame_cnt_w),
    .elapsed  (elapsed_w)
);

// File: tb/rx_coalesce_irq_test.sv
module rx_coalesce_irq_test;

    localparam int LEN_W = 11, BYTE_W = 16, FRAME_W = 8, TIME_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enq_valid = 0, deq_valid = 0, tick = 0, irq_ack = 0;
    logic [LEN_W-1:0] enq_len = '0, deq_len = '0;
    logic [TIME_W-1:0] dur_limit = 16'd3;
    logic [BYTE_W-1:0] byte_limit = 16'd1000;
    logic [FRAME_W-1:0] frame_limit = 8'd2;
    logic dur_en = 0, byte_en = 0, frame_en = 0;
    logic irq, stat_dur, stat_byte, stat_frame;

    always #10 clk = ~clk;

    rx_coalesce_irq #(.LEN_W(LEN_W), .BYTE_W(BYTE_W), .FRAME_W(FRAME_W), .TIME_W(TIME_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .enq_valid(enq_valid), .enq_len(enq_len),
        .deq_valid(deq_valid), .deq_len(deq_len),
        .tick(tick),
        .dur_limit(dur_limit), .byte_limit(byte_limit), .frame_limit(frame_limit),
        .dur_en(dur_en), .byte_en(byte_en), .frame_en(frame_en),
        .irq_ack(irq_ack),
        .irq(irq), .stat_dur(stat_dur), .stat_byte(stat_byte), .stat_frame(stat_frame)
    );

    typedef struct {
        bit       irq;
        bit [2:0] stat;
        string    tag;
    } exp_t;

    exp_t exp_q[$];
    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    // monitor: compares expected items at the falling edge
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_vec++;
            if (irq !== e.irq || {stat_dur, stat_byte, stat_frame} !== e.stat) begin
                n_bad++;
                $display("FAIL %s: irq/stat actual %0b/%03b expected %0b/%03b",
                         e.tag, irq, {stat_dur, stat_byte, stat_frame}, e.irq, e.stat);
            end
        end
    end

    task automatic expect_out(input bit i, input bit [2:0] s, input string tag);
        exp_t e;
        e.irq = i; e.stat = s; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // one clock: drive strobes, pass the edge, release them
    task automatic step(input bit e, input int el, input bit d, input int dl,
                        input bit t, input bit a);
        enq_valid = e; enq_len = LEN_W'(el);
        deq_valid = d; deq_len = LEN_W'(dl);
        tick = t; irq_ack = a;
        @(posedge clk); #1;
        enq_valid = 0; deq_valid = 0; tick = 0; irq_ack = 0;
    endtask

    task automatic idle(); step(0, 0, 0, 0, 0, 0); endtask
    task automatic ack();  step(0, 0, 0, 0, 0, 1); endtask

    task automatic finish_run();
        @(negedge clk); #1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        expect_out(0, 3'b000, "R1 reset state");

        // frame condition
        frame_en = 1;
        step(1, 64, 0, 0, 0, 0);
        step(1, 64, 0, 0, 0, 0);
        expect_out(0, 3'b000, "R2 two frames not above limit");
        step(1, 64, 0, 0, 0, 0);
        expect_out(0, 3'b000, "R2 irq lags count by one edge");
        idle();
        expect_out(1, 3'b000, "R2 three frames raise irq");
        ack();
        expect_out(1, 3'b001, "R7 R8 ack while frames above limit");
        step(0, 0, 1, 64, 0, 0);
        expect_out(1, 3'b001, "R7 held without ack");
        ack();
        expect_out(0, 3'b000, "R7 R8 ack clears irq");
        step(0, 0, 1, 64, 0, 0);
        step(0, 0, 1, 64, 0, 0);
        idle();
        expect_out(0, 3'b000, "R6 drained");

        // byte condition, frame cause disabled
        frame_en = 0; byte_en = 1;
        step(1, 600, 0, 0, 0, 0);
        step(1, 500, 0, 0, 0, 0);
        expect_out(0, 3'b000, "R3 irq lags byte count");
        idle();
        expect_out(1, 3'b000, "R3 1100 bytes above 1000");
        ack();
        expect_out(1, 3'b010, "R3 R8 byte cause latched");
        step(1, 200, 1, 600, 0, 0);
        expect_out(1, 3'b010, "R6 same-cycle enq/deq");
        ack();
        expect_out(0, 3'b000, "R6 R7 700 bytes after swap");
        step(1, 301, 0, 0, 0, 0);
        expect_out(0, 3'b000, "R6 irq lags");
        idle();
        expect_out(1, 3'b000, "R6 700+301 above limit");
        ack();
        expect_out(1, 3'b010, "R9 frame cause disabled with 3 frames");
        step(0, 0, 1, 500, 0, 0);
        step(0, 0, 1, 200, 0, 0);
        step(0, 0, 1, 301, 0, 0);
        ack();
        expect_out(0, 3'b000, "R6 all bytes removed");

        // dequeue on empty queue is ignored
        byte_limit = 16'd50;
        step(0, 0, 1, 100, 0, 0);
        idle();
        idle();
        expect_out(0, 3'b000, "R6 empty dequeue ignored");
        step(1, 60, 0, 0, 0, 0);
        idle();
        expect_out(1, 3'b000, "R3 60 bytes above 50");
        ack();
        expect_out(1, 3'b010, "R8 byte status");
        step(0, 0, 1, 60, 0, 0);
        ack();
        expect_out(0, 3'b000, "R7 cleared");
        byte_en = 0;

        // dwell condition
        dur_en = 1;
        step(1, 64, 0, 0, 0, 0);
        for (int k = 0; k < 3; k++) begin
            step(0, 0, 0, 0, 1, 0);
            expect_out(0, 3'b000, "R4 dwell not above limit");
        end
        idle();
        expect_out(0, 3'b000, "R4 cycles without tick do not count");
        step(0, 0, 0, 0, 1, 0);
        expect_out(0, 3'b000, "R4 irq lags dwell");
        idle();
        expect_out(1, 3'b000, "R4 four ticks raise irq");
        ack();
        expect_out(1, 3'b100, "R4 R8 dwell cause latched");
        step(0, 0, 1, 64, 0, 0);
        expect_out(1, 3'b100, "R7 held");
        ack();
        expect_out(0, 3'b000, "R5 empty queue clears dwell");

        // dwell restarts from zero
        step(1, 64, 0, 0, 0, 0);
        for (int k = 0; k < 3; k++) step(0, 0, 0, 0, 1, 0);
        idle();
        expect_out(0, 3'b000, "R5 timer restarted from zero");
        step(0, 0, 0, 0, 1, 0);
        idle();
        expect_out(1, 3'b000, "R5 restarted timer reaches limit");
        ack();
        expect_out(1, 3'b100, "R8 dwell status again");
        step(0, 0, 1, 64, 0, 0);
        ack();
        expect_out(0, 3'b000, "R7 cleared after dwell");

        // everything disabled
        dur_en = 0;
        step(1, 64, 0, 0, 0, 0);
        step(1, 900, 0, 0, 0, 0);
        step(1, 900, 0, 0, 0, 0);
        for (int k = 0; k < 6; k++) step(0, 0, 0, 0, 1, 0);
        idle();
        expect_out(0, 3'b000, "R9 disabled causes do not set irq");
        ack();
        expect_out(0, 3'b000, "R9 disabled causes leave status clear");

        done = 1;
        finish_run();
    end

endmodule